// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the command interpreter that sits in front of a byte-wide parallel NOR flash array. The host bus delivers write cycles. Each cycle is an address, a data byte and a one-cycle write strobe. The decoder checks for the two-write unlock prefix and then for a command byte. From these it produces one-cycle requests to the program and erase engine. The engine is external and reports back through a single busy input.

The decoder also drives a read-source select. The read path uses it to return array contents, identification bytes or operation status. Identification bytes are built inside the block from the read address and a vector of per-sector protection flags. A shortened programming mode skips the unlock prefix until the host exits it with a two-write sequence.

The engine is expected to raise busy in the cycle after a program, erase or resume request. It holds busy high until the operation ends.

Top module: `nor_cmd_decoder`

## Requirements
- R1: While reset is asserted and right after it, rd_sel is 0 (array), bypass_active is low and no request output is high.
- R2: An unlock sequence is data AAh at address 555h, then data 55h at address 2AAh, then a command byte at 555h. Only wr_addr[10:0] is compared, so upper address bits are ignored. A command byte of 90h selects identification mode, and rd_sel then reads 1.
- R3: A program takes four writes. After the unlock pair and A0h, the fourth write raises pgm_req for exactly one cycle. In that cycle req_addr and req_data hold that write's address and data.
- R4: An erase takes six writes: unlock pair, 80h, unlock pair, then a final write. The final write is either 10h at 555h, which pulses chip_erase_req, or 30h at any address, which pulses sect_erase_req with req_addr equal to that address.
- R5: A wrong address, a wrong data value or an out-of-order write inside a partial sequence returns the decoder to array read with no request.
- R6: Data F0h at any address returns the decoder to array read from idle, from identification mode or from any partial standard sequence. In identification mode, other writes are ignored.
- R7: id_data is selected by rd_addr[7:0]. Offset 00h gives 01h. Offset 01h gives EDh when TOP_BOOT=1 and 6Dh when TOP_BOOT=0. Offset 02h gives 01h or 00h from sect_prot[rd_addr[16:12]]. Any other offset gives 00h.
- R8: Command byte 20h after the unlock pair sets bypass_active. In bypass, A0h followed by any write pulses pgm_req. Every other write is ignored.
- R9: In bypass, 90h followed by 00h clears bypass_active and returns to array read. 90h followed by any other byte stays in bypass.
- R10: From a request until busy is sampled low, rd_sel is 2 (status) and writes are ignored, F0h included. When busy falls, the decoder returns to bypass if bypass was active, and to array read otherwise.
- R11: req_addr and req_data do not change while an operation is running.
- R12: B0h while a sector erase runs pulses suspend_req and sets rd_sel to 0. In suspend, 30h pulses resume_req and status reads return. B0h is ignored during program and chip erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data |
| rd_addr | input | ADDR_W | Read address for identification bytes |
| sect_prot | input | 2**SECT_W | Per-sector protection flags |
| busy | input | 1 | Engine busy, high the cycle after a request until done |
| rd_sel | output | 2 | Read source: 0 array, 1 identification, 2 status |
| id_data | output | 8 | Identification byte for rd_addr |
| pgm_req | output | 1 | Byte program request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| sect_erase_req | output | 1 | Sector erase request pulse |
| suspend_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| req_addr | output | ADDR_W | Latched operation address |
| req_data | output | 8 | Latched program data |
| bypass_active | output | 1 | Shortened programming mode active |

## Verification
The in-line properties watch the following on every cycle:
- at most one request pulse is high at a time, and each program pulse lasts a single cycle;
- status select holds while busy is high, even under F0h writes;
- the latched address and data stay still while status is selected;
- bypass is only ever left on a 00h write;
- a suspend coincides with array select.

Only the scenarios can show that each unlock, command and abort path lands in the right mode, and that the six-write erase forms choose the right request. They also cover the suspend and resume round trip, the return into bypass after a program, and the identification bytes for protected and unprotected sectors. Random write streams, biased toward the unlock and command values, are compared against a cycle model in the bench.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int CMP_W = 11;

    localparam logic [CMP_W-1:0] ADR_FIRST  = 11'h555;
    localparam logic [CMP_W-1:0] ADR_SECOND = 11'h2AA;

    localparam logic [7:0] BYTE_UNLK_A  = 8'hAA;
    localparam logic [7:0] BYTE_UNLK_B  = 8'h55;
    localparam logic [7:0] BYTE_PROGRAM = 8'hA0;
    localparam logic [7:0] BYTE_IDENT   = 8'h90;
    localparam logic [7:0] BYTE_ERASE   = 8'h80;
    localparam logic [7:0] BYTE_BYPASS  = 8'h20;
    localparam logic [7:0] BYTE_CHIP    = 8'h10;
    localparam logic [7:0] BYTE_SECTOR  = 8'h30;
    localparam logic [7:0] BYTE_ABORT   = 8'hF0;
    localparam logic [7:0] BYTE_SUSPEND = 8'hB0;
    localparam logic [7:0] BYTE_RESUME  = 8'h30;
    localparam logic [7:0] BYTE_BYP_END = 8'h00;

    localparam logic [7:0] MAKER_CODE   = 8'h01;
    localparam logic [7:0] DEV_CODE_TOP = 8'hED;
    localparam logic [7:0] DEV_CODE_BOT = 8'h6D;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM,
        ST_ERS_UNL0,
        ST_ERS_UNL1,
        ST_ERS_CMD,
        ST_IDENT,
        ST_BYP,
        ST_BYP_PGM,
        ST_BYP_EXIT,
        ST_RUN,
        ST_SUSP
    } dec_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PGM,
        OP_CHIP,
        OP_SECT
    } op_e;

    localparam logic [1:0] SEL_ARRAY  = 2'd0;
    localparam logic [1:0] SEL_IDENT  = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;

endpackage

// File: rtl/nor_cycle_match.sv
module nor_cycle_match
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              at_first,
    output logic              is_unlk_a,
    output logic              is_unlk_b
);
    logic [CMP_W-1:0] low_addr;

    always_comb begin
        low_addr  = addr[CMP_W-1:0];
        at_first  = (low_addr == ADR_FIRST);
        is_unlk_a = at_first && (data == BYTE_UNLK_A);
        is_unlk_b = (low_addr == ADR_SECOND) && (data == BYTE_UNLK_B);
    end
endmodule

// File: rtl/nor_ident_rom.sv
module nor_ident_rom
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int SECT_W   = 5,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [(1<<SECT_W)-1:0]  sect_prot,
    output logic [7:0]              id_data
);
    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic [7:0]        dev_code;
    logic [SECT_W-1:0] sect_idx;

    generate
        if (TOP_BOOT) begin : g_top
            assign dev_code = DEV_CODE_TOP;
        end else begin : g_bot
            assign dev_code = DEV_CODE_BOT;
        end
    endgenerate

    always_comb begin
        sect_idx = rd_addr[ADDR_W-1:SECT_LSB];
        case (rd_addr[7:0])
            8'h00:   id_data = MAKER_CODE;
            8'h01:   id_data = dev_code;
            8'h02:   id_data = {7'd0, sect_prot[sect_idx]};
            default: id_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int SECT_W   = 5,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [(1<<SECT_W)-1:0]  sect_prot,
    input  logic                    busy,
    output logic [1:0]              rd_sel,
    output logic [7:0]              id_data,
    output logic                    pgm_req,
    output logic                    chip_erase_req,
    output logic                    sect_erase_req,
    output logic                    suspend_req,
    output logic                    resume_req,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [7:0]              req_data,
    output logic                    bypass_active
);
    typedef struct packed {
        dec_state_e        state;
        op_e               op;
        logic              bypass;
        logic              pgm;
        logic              chip;
        logic              sect;
        logic              susp;
        logic              res;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } dec_regs_t;

    dec_regs_t r_d, r_q;
    logic at_first, is_unlk_a, is_unlk_b;

    nor_cycle_match #(.ADDR_W(ADDR_W)) u_match (
        .addr      (wr_addr),
        .data      (wr_data),
        .at_first  (at_first),
        .is_unlk_a (is_unlk_a),
        .is_unlk_b (is_unlk_b)
    );

    nor_ident_rom #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .TOP_BOOT(TOP_BOOT)) u_ident (
        .rd_addr   (rd_addr),
        .sect_prot (sect_prot),
        .id_data   (id_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.pgm  = 1'b0;
        r_d.chip = 1'b0;
        r_d.sect = 1'b0;
        r_d.susp = 1'b0;
        r_d.res  = 1'b0;
        case (r_q.state)
            ST_READ: begin
                if (wr_stb && is_unlk_a) r_d.state = ST_UNL1;
            end
            ST_UNL1: begin
                if (wr_stb) r_d.state = is_unlk_b ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (wr_stb) begin
                    r_d.state = ST_READ;
                    if (at_first) begin
                        case (wr_data)
                            BYTE_PROGRAM: r_d.state = ST_PGM;
                            BYTE_IDENT:   r_d.state = ST_IDENT;
                            BYTE_ERASE:   r_d.state = ST_ERS_UNL0;
                            BYTE_BYPASS: begin
                                r_d.state  = ST_BYP;
                                r_d.bypass = 1'b1;
                            end
                            default:      r_d.state = ST_READ;
                        endcase
                    end
                end
            end
            ST_PGM: begin
                if (wr_stb) begin
                    if (wr_data == BYTE_ABORT) begin
                        r_d.state = ST_READ;
                    end else begin
                        r_d.state = ST_RUN;
                        r_d.op    = OP_PGM;
                        r_d.pgm   = 1'b1;
                        r_d.addr  = wr_addr;
                        r_d.data  = wr_data;
                    end
                end
            end
            ST_ERS_UNL0: begin
                if (wr_stb) r_d.state = is_unlk_a ? ST_ERS_UNL1 : ST_READ;
            end
            ST_ERS_UNL1: begin
                if (wr_stb) r_d.state = is_unlk_b ? ST_ERS_CMD : ST_READ;
            end
            ST_ERS_CMD: begin
                if (wr_stb) begin
                    if (at_first && wr_data == BYTE_CHIP) begin
                        r_d.state = ST_RUN;
                        r_d.op    = OP_CHIP;
                        r_d.chip  = 1'b1;
                        r_d.addr  = wr_addr;
                        r_d.data  = wr_data;
                    end else if (wr_data == BYTE_SECTOR) begin
                        r_d.state = ST_RUN;
                        r_d.op    = OP_SECT;
                        r_d.sect  = 1'b1;
                        r_d.addr  = wr_addr;
                        r_d.data  = wr_data;
                    end else begin
                        r_d.state = ST_READ;
                    end
                end
            end
            ST_IDENT: begin
                if (wr_stb && wr_data == BYTE_ABORT) r_d.state = ST_READ;
            end
            ST_BYP: begin
                if (wr_stb) begin
                    if (wr_data == BYTE_PROGRAM)    r_d.state = ST_BYP_PGM;
                    else if (wr_data == BYTE_IDENT) r_d.state = ST_BYP_EXIT;
                end
            end
            ST_BYP_PGM: begin
                if (wr_stb) begin
                    r_d.state = ST_RUN;
                    r_d.op    = OP_PGM;
                    r_d.pgm   = 1'b1;
                    r_d.addr  = wr_addr;
                    r_d.data  = wr_data;
                end
            end
            ST_BYP_EXIT: begin
                if (wr_stb) begin
                    if (wr_data == BYTE_BYP_END) begin
                        r_d.state  = ST_READ;
                        r_d.bypass = 1'b0;
                    end else begin
                        r_d.state = ST_BYP;
                    end
                end
            end
            ST_RUN: begin
                if (!busy) begin
                    r_d.state = r_q.bypass ? ST_BYP : ST_READ;
                    r_d.op    = OP_NONE;
                end else if (wr_stb && r_q.op == OP_SECT && wr_data == BYTE_SUSPEND) begin
                    r_d.state = ST_SUSP;
                    r_d.susp  = 1'b1;
                end
            end
            ST_SUSP: begin
                if (wr_stb && wr_data == BYTE_RESUME) begin
                    r_d.state = ST_RUN;
                    r_d.res   = 1'b1;
                end
            end
            default: r_d.state = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_READ, op: OP_NONE, addr: '0, data: '0, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.state)
            ST_IDENT: rd_sel = SEL_IDENT;
            ST_RUN:   rd_sel = SEL_STATUS;
            default:  rd_sel = SEL_ARRAY;
        endcase
    end

    assign pgm_req        = r_q.pgm;
    assign chip_erase_req = r_q.chip;
    assign sect_erase_req = r_q.sect;
    assign suspend_req    = r_q.susp;
    assign resume_req     = r_q.res;
    assign req_addr       = r_q.addr;
    assign req_data       = r_q.data;
    assign bypass_active  = r_q.bypass;

    // R3: request pulses never overlap
    a_r3_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_req, chip_erase_req, sect_erase_req, suspend_req, resume_req}));

    // R3: a program request lasts a single cycle
    a_r3_pgm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |=> !pgm_req);

    // R10: status select survives any non-suspend write while busy
    a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_STATUS && busy && !(wr_stb && wr_data == BYTE_SUSPEND))
        |=> rd_sel == SEL_STATUS);

    // R11: latched operands are frozen while status is selected
    a_r11_operands_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_STATUS) |=> ($stable(req_addr) && $stable(req_data)));

    // R9: bypass is only left through a 00h write
    a_r9_bypass_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bypass_active) |-> ($past(wr_stb) && $past(wr_data) == BYTE_BYP_END));

    // R12: a suspend hands the read path back to the array
    a_r12_suspend_array: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> rd_sel == SEL_ARRAY);
endmodule

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   sect_prot = 32'h8000_0005;
    logic          busy = 1'b0;
    logic [1:0]    rd_sel;
    logic [7:0]    id_data;
    logic          pgm_req, chip_erase_req, sect_erase_req, suspend_req, resume_req;
    logic [AW-1:0] req_addr;
    logic [7:0]    req_data;
    logic          bypass_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state: 0 read,1 u1,2 u2,3 pgm,4 e0,5 e1,6 ecmd,7 ident,8 byp,9 bpgm,10 bexit,11 run,12 susp
    int         m_st = 0;
    bit         m_byp = 0;
    int         m_op = 0;
    logic [AW-1:0] m_addr = '0;
    logic [7:0] m_data = '0;
    logic [4:0] m_pulse = '0;
    int         busy_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .sect_prot(sect_prot), .busy(busy), .rd_sel(rd_sel),
        .id_data(id_data), .pgm_req(pgm_req), .chip_erase_req(chip_erase_req),
        .sect_erase_req(sect_erase_req), .suspend_req(suspend_req), .resume_req(resume_req),
        .req_addr(req_addr), .req_data(req_data), .bypass_active(bypass_active)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_sel();
        if (m_st == 7)  return 2'd1;
        if (m_st == 11) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [7:0] exp_id(logic [AW-1:0] a);
        case (a[7:0])
            8'h00:   return 8'h01;
            8'h01:   return 8'hED;
            8'h02:   return {7'd0, sect_prot[a[16:12]]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic launch(int op, logic [AW-1:0] a, logic [7:0] d, int bit_idx);
        m_st = 11; m_op = op; m_addr = a; m_data = d; m_pulse[bit_idx] = 1'b1;
    endtask

    // pulse bits: 4 pgm, 3 chip, 2 sect, 1 suspend, 0 resume
    task automatic model_step(bit s, logic [AW-1:0] a, logic [7:0] d, bit b);
        bit f1, ua, ub;
        f1 = (a[10:0] == 11'h555);
        ua = f1 && d == 8'hAA;
        ub = (a[10:0] == 11'h2AA) && d == 8'h55;
        m_pulse = '0;
        if (m_st == 11) begin
            if (!b) begin m_st = m_byp ? 8 : 0; m_op = 0; end
            else if (s && m_op == 3 && d == 8'hB0) begin m_st = 12; m_pulse[1] = 1'b1; end
        end else if (m_st == 12) begin
            if (s && d == 8'h30) begin m_st = 11; m_pulse[0] = 1'b1; end
        end else if (s) begin
            case (m_st)
                0: if (ua) m_st = 1;
                1: m_st = ub ? 2 : 0;
                2: begin
                    m_st = 0;
                    if (f1 && d == 8'hA0) m_st = 3;
                    else if (f1 && d == 8'h90) m_st = 7;
                    else if (f1 && d == 8'h80) m_st = 4;
                    else if (f1 && d == 8'h20) begin m_st = 8; m_byp = 1; end
                end
                3: if (d == 8'hF0) m_st = 0; else launch(1, a, d, 4);
                4: m_st = ua ? 5 : 0;
                5: m_st = ub ? 6 : 0;
                6: if (f1 && d == 8'h10) launch(2, a, d, 3);
                   else if (d == 8'h30) launch(3, a, d, 2);
                   else m_st = 0;
                7: if (d == 8'hF0) m_st = 0;
                8: if (d == 8'hA0) m_st = 9; else if (d == 8'h90) m_st = 10;
                9: launch(1, a, d, 4);
                10: if (d == 8'h00) begin m_st = 0; m_byp = 0; end else m_st = 8;
                default: m_st = 0;
            endcase
        end
    endtask

    task automatic cyc(bit s, logic [AW-1:0] a, logic [7:0] d, string tag);
        wr_stb = s; wr_addr = a; wr_data = d;
        model_step(s, a, d, busy);
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
        check(tag, rd_sel, exp_sel(), "rd_sel");
        check("R8", bypass_active, m_byp, "bypass_active");
        check("R3", {pgm_req, chip_erase_req, sect_erase_req, suspend_req, resume_req},
              m_pulse, "request pulses");
        if (m_st == 11 || m_pulse != 0) begin
            check("R11", req_addr, m_addr, "req_addr");
            check("R11", req_data, m_data, "req_data");
        end
        check("R7", id_data, exp_id(rd_addr), "id_data");
        if (m_pulse[4] | m_pulse[3] | m_pulse[2] | m_pulse[0]) begin
            busy = 1'b1; busy_left = 2 + int'($urandom % 5);
        end else if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) busy = 1'b0;
        end
    endtask

    task automatic settle(string tag);
        for (int i = 0; i < 12; i++) cyc(1'b0, '0, 8'h00, tag);
    endtask

    task automatic unlock(string tag);
        cyc(1'b1, 17'h1F555, 8'hAA, tag);
        cyc(1'b1, 17'h0A2AA, 8'h55, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] cmds [9];
        int pick;
        logic [AW-1:0] ra;
        void'($urandom(32'd4242));
        cmds = '{8'hA0, 8'h90, 8'h80, 8'h20, 8'h10, 8'h30, 8'hF0, 8'hB0, 8'h00};
        repeat (3) @(negedge clk);
        check("R1", rd_sel, 2'd0, "rd_sel in reset");
        check("R1", {pgm_req, chip_erase_req, sect_erase_req, suspend_req, resume_req}, 5'd0, "requests in reset");
        rst_n = 1'b1;
        cyc(1'b0, '0, 8'h00, "R1");
        check("R1", bypass_active, 1'b0, "bypass after reset");

        // R2 identification entry, R7 codes, R6 exit
        unlock("R2");
        cyc(1'b1, 17'h00555, 8'h90, "R2");
        check("R2", rd_sel, 2'd1, "ident select");
        rd_addr = 17'h00000; cyc(1'b0, '0, 8'h00, "R7");
        rd_addr = 17'h00001; cyc(1'b0, '0, 8'h00, "R7");
        rd_addr = 17'h02002; cyc(1'b0, '0, 8'h00, "R7");
        rd_addr = 17'h1F002; cyc(1'b0, '0, 8'h00, "R7");
        rd_addr = 17'h03002; cyc(1'b0, '0, 8'h00, "R7");
        rd_addr = 17'h00005; cyc(1'b0, '0, 8'h00, "R7");
        cyc(1'b1, 17'h00555, 8'h77, "R6");
        cyc(1'b1, 17'h01234, 8'hF0, "R6");
        check("R6", rd_sel, 2'd0, "reset from ident");

        // R3 program, R10 ignored writes while busy
        unlock("R3");
        cyc(1'b1, 17'h00555, 8'hA0, "R3");
        cyc(1'b1, 17'h12345, 8'h3C, "R3");
        check("R3", pgm_req, 1'b1, "program request");
        cyc(1'b1, 17'h00000, 8'hF0, "R10");
        check("R10", rd_sel, 2'd2, "F0 ignored while busy");
        cyc(1'b1, 17'h00555, 8'hB0, "R12");
        settle("R10");

        // R5 wrong address and order
        cyc(1'b1, 17'h00555, 8'hAA, "R5");
        cyc(1'b1, 17'h00555, 8'h55, "R5");
        cyc(1'b1, 17'h00555, 8'h90, "R5");
        check("R5", rd_sel, 2'd0, "no ident after bad unlock");
        cyc(1'b1, 17'h002AA, 8'h55, "R5");
        unlock("R5");
        cyc(1'b1, 17'h00554, 8'h90, "R5");

        // R4 chip erase, suspend ignored
        unlock("R4");
        cyc(1'b1, 17'h00555, 8'h80, "R4");
        unlock("R4");
        cyc(1'b1, 17'h00555, 8'h10, "R4");
        check("R4", chip_erase_req, 1'b1, "chip erase request");
        cyc(1'b1, 17'h00555, 8'hB0, "R12");
        check("R12", suspend_req, 1'b0, "no suspend in chip erase");
        settle("R10");

        // R4 sector erase, R12 suspend and resume
        unlock("R4");
        cyc(1'b1, 17'h00555, 8'h80, "R4");
        unlock("R4");
        cyc(1'b1, 17'h0A000, 8'h30, "R4");
        check("R4", req_addr, 17'h0A000, "sector address");
        cyc(1'b1, 17'h00000, 8'hB0, "R12");
        check("R12", suspend_req, 1'b1, "suspend pulse");
        cyc(1'b1, 17'h00000, 8'hF0, "R12");
        cyc(1'b1, 17'h00000, 8'h30, "R12");
        check("R12", rd_sel, 2'd2, "resumed status");
        settle("R10");

        // R6 abort partial sequences
        unlock("R6");
        cyc(1'b1, 17'h00555, 8'hA0, "R6");
        cyc(1'b1, 17'h04000, 8'hF0, "R6");
        check("R6", pgm_req, 1'b0, "abort before program");
        cyc(1'b1, 17'h00555, 8'hAA, "R6");
        cyc(1'b1, 17'h00123, 8'hF0, "R6");

        // R8 bypass programming, R9 exit
        unlock("R8");
        cyc(1'b1, 17'h00555, 8'h20, "R8");
        check("R8", bypass_active, 1'b1, "bypass set");
        cyc(1'b1, 17'h00555, 8'h77, "R8");
        cyc(1'b1, 17'h00000, 8'hF0, "R8");
        cyc(1'b1, 17'h00000, 8'hA0, "R8");
        cyc(1'b1, 17'h1ABCD, 8'hF0, "R8");
        check("R8", pgm_req, 1'b1, "bypass program request");
        settle("R10");
        check("R10", bypass_active, 1'b1, "back to bypass");
        cyc(1'b1, 17'h00000, 8'h90, "R9");
        cyc(1'b1, 17'h00000, 8'h55, "R9");
        check("R9", bypass_active, 1'b1, "bad exit stays");
        cyc(1'b1, 17'h00000, 8'h90, "R9");
        cyc(1'b1, 17'h00000, 8'h00, "R9");
        check("R9", bypass_active, 1'b0, "bypass cleared");

        // random streams against the model
        for (int i = 0; i < 4000; i++) begin
            ra = AW'($urandom);
            ra[7:0] = 8'($urandom % 4);
            rd_addr = ra;
            pick = int'($urandom % 7);
            case (pick)
                0: cyc(1'b1, {6'($urandom), 11'h555}, 8'hAA, "R2");
                1: cyc(1'b1, {6'($urandom), 11'h2AA}, 8'h55, "R5");
                2, 3: cyc(1'b1, {6'($urandom), 11'h555}, cmds[$urandom % 9], "R10");
                4: cyc(1'b1, AW'($urandom), cmds[$urandom % 9], "R6");
                5: cyc(1'b1, AW'($urandom), 8'($urandom), "R5");
                default: cyc(1'b0, AW'($urandom), 8'($urandom), "R10");
            endcase
        end
        finish_run();
    end
endmodule